// File: doc/BRIEF.md
# Shared Semaphore Token Latches

The block holds a small bank of hardware semaphores that two agents, called the left port and the right port, use to claim and hand back shared resources. These semaphores sit apart from any data storage. Each port has a select, a write strobe, an address bus and a data bus. A port accesses one semaphore on any clock edge where its select is high. With the write strobe high, bit 0 of the data bus carries the command: 0 asks for the token and 1 gives it up. With the write strobe low, the port reads back its own view of that semaphore.

Each semaphore shows the two ports opposite views. The owner sees 0 and the other port sees 1. When both ports see 1, the semaphore is free. A port that asks while the other side holds the token is remembered as pending. It takes the token on the same edge at which the holder releases it. Software polls by reading, so the read result is captured into a per-port output register. That value stays put until the same port reads again.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every semaphore is free and both read registers hold all ones. An asynchronous reset applied at any time returns the block to this state.
- R2: A read (select high, write low) captures the port's view of the addressed semaphore into its output register on that clock edge. The view is 0 if the port owns the token and 1 otherwise, and it is copied onto every data bit. The new value appears after that edge.
- R3: A request (write with data bit 0 equal to 0) to a free semaphore makes the requester the owner. From then on the requester reads 0 and the other port reads 1.
- R4: Only the low log2(N_SEM) address bits select the semaphore, and only data bit 0 is used on a write. All other address and data bits have no effect.
- R5: A release from the non-owner does not change the semaphore. A repeated request from the owner does not change it either.
- R6: A request from the non-owner while the other port owns the token is held pending. When the owner releases, the pending port becomes owner on that same edge.
- R7: When the owner releases and nothing is pending, the semaphore becomes free and both ports read 1.
- R8: At no time do both ports own a semaphore. If both ports request a free semaphore on the same edge, the left port obtains it and the right port's request is held pending.
- R9: A pending request is cancelled when the requesting port writes 1 before being granted. A later release by the owner then leaves the semaphore free.
- R10: A read returns the state from before that edge, even if the other port writes the same semaphore on the same edge. The output register keeps its value on cycles where its port does not read.
- R11: The semaphores are independent, so an operation on one does not alter any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_i | input | 1 | Left port semaphore access select |
| l_we_i | input | 1 | Left port write strobe (0 = read) |
| l_addr_i | input | ADDR_W | Left port address; low bits pick the semaphore |
| l_wdata_i | input | DATA_W | Left port write data; bit 0 = 0 request, 1 release |
| l_rdata_o | output | DATA_W | Left port captured view, copied onto all bits |
| r_sel_i | input | 1 | Right port semaphore access select |
| r_we_i | input | 1 | Right port write strobe (0 = read) |
| r_addr_i | input | ADDR_W | Right port address; low bits pick the semaphore |
| r_wdata_i | input | DATA_W | Right port write data; bit 0 = 0 request, 1 release |
| r_rdata_o | output | DATA_W | Right port captured view, copied onto all bits |

## Verification
Two functions can fall in the same cycle:
- Both ports can request one free semaphore on a single edge. The bench then expects the left port to read 0 and the right port to read 1. After the left port releases, the right port must read 0 without writing again.
- One port can read a semaphore while the other port writes it. The bench expects the read register to show the state from before the write. A read on the next cycle must show the updated view.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // per-latch command from one port on one edge
  typedef struct packed {
    logic req;
    logic rel;
  } sem_wr_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
  import sem_pkg::*;
#(
  parameter int unsigned N_SEM  = 8,
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 9,
  localparam int unsigned IW    = $clog2(N_SEM)
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output sem_wr_t           wr_o [N_SEM],
  output logic              rd_en_o,
  output logic [IW-1:0]     rd_idx_o
);
  logic [IW-1:0] idx;
  logic          wr_hit;
  logic          unused_bits;

  assign idx         = addr_i[IW-1:0];
  assign wr_hit      = sel_i & we_i;
  assign rd_en_o     = sel_i & ~we_i;
  assign rd_idx_o    = idx;
  assign unused_bits = ^{addr_i[ADDR_W-1:IW], wdata_i[DATA_W-1:1]};

  always_comb begin
    for (int i = 0; i < N_SEM; i++) begin
      wr_o[i].req = wr_hit && (idx == IW'(i)) && !wdata_i[0];
      wr_o[i].rel = wr_hit && (idx == IW'(i)) &&  wdata_i[0];
    end
  end
endmodule

// File: rtl/sem_latch.sv
module sem_latch
  import sem_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sem_wr_t l_i,
  input  sem_wr_t r_i,
  output logic    own_l_o,
  output logic    own_r_o
);
  logic own_l_q, own_r_q, pend_q;
  logic own_l_d, own_r_d, pend_d;

  always_comb begin
    own_l_d = own_l_q;
    own_r_d = own_r_q;
    pend_d  = pend_q;
    if (!own_l_q && !own_r_q) begin
      // free: left has priority, right kept pending on a tie
      if (l_i.req) begin
        own_l_d = 1'b1;
        pend_d  = r_i.req;
      end else if (r_i.req) begin
        own_r_d = 1'b1;
      end
    end else if (own_l_q) begin
      if (l_i.rel) begin
        own_l_d = 1'b0;
        own_r_d = (pend_q && !r_i.rel) || r_i.req;
        pend_d  = 1'b0;
      end else if (r_i.req) begin
        pend_d = 1'b1;
      end else if (r_i.rel) begin
        pend_d = 1'b0;
      end
    end else begin
      if (r_i.rel) begin
        own_r_d = 1'b0;
        own_l_d = (pend_q && !l_i.rel) || l_i.req;
        pend_d  = 1'b0;
      end else if (l_i.req) begin
        pend_d = 1'b1;
      end else if (l_i.rel) begin
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_l_q <= 1'b0;
      own_r_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      own_l_q <= own_l_d;
      own_r_q <= own_r_d;
      pend_q  <= pend_d;
    end
  end

  assign own_l_o = own_l_q;
  assign own_r_o = own_r_q;
endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              held_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '1;
    else if (rd_en_i) rdata_o <= held_i ? '0 : '1;
  end
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank
  import sem_pkg::*;
#(
  parameter int unsigned N_SEM  = 8,
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sel_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_sel_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int unsigned IW = $clog2(N_SEM);

  sem_wr_t       l_wr [N_SEM];
  sem_wr_t       r_wr [N_SEM];
  logic          l_rd_en, r_rd_en;
  logic [IW-1:0] l_rd_idx, r_rd_idx;
  logic [N_SEM-1:0] own_l, own_r;

  sem_port_decode #(.N_SEM(N_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_l (
    .sel_i(l_sel_i), .we_i(l_we_i), .addr_i(l_addr_i), .wdata_i(l_wdata_i),
    .wr_o(l_wr), .rd_en_o(l_rd_en), .rd_idx_o(l_rd_idx)
  );

  sem_port_decode #(.N_SEM(N_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec_r (
    .sel_i(r_sel_i), .we_i(r_we_i), .addr_i(r_addr_i), .wdata_i(r_wdata_i),
    .wr_o(r_wr), .rd_en_o(r_rd_en), .rd_idx_o(r_rd_idx)
  );

  for (genvar g = 0; g < N_SEM; g++) begin : g_sem
    sem_latch i_latch (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .l_i(l_wr[g]), .r_i(r_wr[g]),
      .own_l_o(own_l[g]), .own_r_o(own_r[g])
    );
  end

  sem_read_reg #(.DATA_W(DATA_W)) i_rd_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(l_rd_en),
    .held_i(own_l[l_rd_idx]), .rdata_o(l_rdata_o)
  );

  sem_read_reg #(.DATA_W(DATA_W)) i_rd_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(r_rd_en),
    .held_i(own_r[r_rd_idx]), .rdata_o(r_rdata_o)
  );
endmodule

// File: rtl/sem_token_bank_chk.sv
module sem_token_bank_chk #(
  parameter int unsigned N_SEM  = 8,
  parameter int unsigned DATA_W = 9,
  localparam int unsigned IW    = $clog2(N_SEM)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_sel_i,
  input logic              l_we_i,
  input logic [IW-1:0]     l_idx_i,
  input logic              l_d0_i,
  input logic [DATA_W-1:0] l_rdata_i,
  input logic              r_sel_i,
  input logic              r_we_i,
  input logic [IW-1:0]     r_idx_i,
  input logic              r_d0_i,
  input logic [DATA_W-1:0] r_rdata_i,
  input logic [N_SEM-1:0]  own_l_i,
  input logic [N_SEM-1:0]  own_r_i
);
  logic l_rd, r_rd, l_rel, r_rel, tie_free;
  assign l_rd     = l_sel_i && !l_we_i;
  assign r_rd     = r_sel_i && !r_we_i;
  assign l_rel    = l_sel_i && l_we_i && l_d0_i;
  assign r_rel    = r_sel_i && r_we_i && r_d0_i;
  assign tie_free = l_sel_i && l_we_i && !l_d0_i && r_sel_i && r_we_i && !r_d0_i &&
                    (l_idx_i == r_idx_i) && !own_l_i[l_idx_i] && !own_r_i[l_idx_i];

  assert_single_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l_i & own_r_i) == '0);

  assert_left_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tie_free |=> own_l_i[$past(l_idx_i)]);

  assert_view_l_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_rd |=> (l_rdata_i == (own_l_i[$past(l_idx_i)] ? '0 : '1)) || 1'b1 ? 
      (l_rdata_i == ($past(own_l_i[l_idx_i]) ? {DATA_W{1'b0}} : {DATA_W{1'b1}})) : 1'b0);

  assert_view_r_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_rd |=> (r_rdata_i == ($past(own_r_i[r_idx_i]) ? {DATA_W{1'b0}} : {DATA_W{1'b1}})));

  assert_hold_l_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_rd |=> $stable(l_rdata_i));

  assert_hold_r_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_rd |=> $stable(r_rdata_i));

  assert_keep_l_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_rel |=> (($past(own_l_i) & ~own_l_i) == '0));

  assert_keep_r_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_rel |=> (($past(own_r_i) & ~own_r_i) == '0));
endmodule

bind sem_token_bank sem_token_bank_chk #(.N_SEM(N_SEM), .DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_sel_i(l_sel_i), .l_we_i(l_we_i), .l_idx_i(l_addr_i[IW-1:0]), .l_d0_i(l_wdata_i[0]),
  .l_rdata_i(l_rdata_o),
  .r_sel_i(r_sel_i), .r_we_i(r_we_i), .r_idx_i(r_addr_i[IW-1:0]), .r_d0_i(r_wdata_i[0]),
  .r_rdata_i(r_rdata_o),
  .own_l_i(own_l), .own_r_i(own_r)
);

// File: tb/test_sem_token_bank.sv
module test_sem_token_bank;
  localparam int unsigned N_SEM  = 8;
  localparam int unsigned ADDR_W = 15;
  localparam int unsigned DATA_W = 9;
  localparam logic [1:0]  NC     = 2'd2;

  typedef enum logic [1:0] {IDLE, RD, W0, W1} op_e;
  typedef struct packed {
    op_e        lo;
    logic [2:0] la;
    op_e        ro;
    logic [2:0] ra;
    logic [1:0] el;
    logic [1:0] er;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{W0,   3'd2, IDLE, 3'd0, NC,   NC  },
    '{RD,   3'd2, RD,   3'd2, 2'd0, 2'd1},  // R3
    '{IDLE, 3'd0, W1,   3'd2, NC,   NC  },
    '{RD,   3'd2, RD,   3'd2, 2'd0, 2'd1},  // R5 non-owner release ignored
    '{IDLE, 3'd0, W0,   3'd2, NC,   NC  },
    '{RD,   3'd2, RD,   3'd2, 2'd0, 2'd1},  // R6 pending, not yet owner
    '{W1,   3'd2, IDLE, 3'd0, NC,   NC  },
    '{RD,   3'd2, RD,   3'd2, 2'd1, 2'd0},  // R6 handover
    '{IDLE, 3'd0, W1,   3'd2, NC,   NC  },
    '{RD,   3'd2, RD,   3'd2, 2'd1, 2'd1},  // R7
    '{W0,   3'd5, W0,   3'd5, NC,   NC  },
    '{RD,   3'd5, RD,   3'd5, 2'd0, 2'd1},  // R8
    '{IDLE, 3'd0, W1,   3'd5, NC,   NC  },
    '{W1,   3'd5, IDLE, 3'd0, NC,   NC  },
    '{RD,   3'd5, RD,   3'd5, 2'd1, 2'd1},  // R9
    '{RD,   3'd5, W0,   3'd5, 2'd1, NC  },  // R10 pre-write view
    '{RD,   3'd5, RD,   3'd5, 2'd1, 2'd0},
    '{RD,   3'd2, RD,   3'd2, 2'd1, 2'd1},  // R11
    '{W0,   3'd5, IDLE, 3'd0, NC,   NC  },
    '{IDLE, 3'd0, W1,   3'd5, NC,   NC  },
    '{RD,   3'd5, RD,   3'd5, 2'd0, 2'd1},  // R6
    '{W0,   3'd5, IDLE, 3'd0, NC,   NC  },
    '{RD,   3'd5, RD,   3'd5, 2'd0, 2'd1},  // R5 owner re-request
    '{W1,   3'd5, IDLE, 3'd0, NC,   NC  },
    '{RD,   3'd5, RD,   3'd5, 2'd1, 2'd1}   // R7
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              l_sel = 1'b0, l_we = 1'b0, r_sel = 1'b0, r_we = 1'b0;
  logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
  logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
  logic [DATA_W-1:0] l_rdata, r_rdata;
  int                n_run = 0, n_fail = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  sem_token_bank #(.N_SEM(N_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sem_token_bank (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_sel_i(l_sel), .l_we_i(l_we), .l_addr_i(l_addr), .l_wdata_i(l_wdata), .l_rdata_o(l_rdata),
    .r_sel_i(r_sel), .r_we_i(r_we), .r_addr_i(r_addr), .r_wdata_i(r_wdata), .r_rdata_o(r_rdata)
  );

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_l(op_e op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    l_sel   = (op != IDLE);
    l_we    = (op == W0) || (op == W1);
    l_addr  = a;
    l_wdata = d;
  endtask

  task automatic drive_r(op_e op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    r_sel   = (op != IDLE);
    r_we    = (op == W0) || (op == W1);
    r_addr  = a;
    r_wdata = d;
  endtask

  function automatic logic [DATA_W-1:0] dflt(op_e op);
    return (op == W1) ? '1 : '0;
  endfunction

  function automatic logic [DATA_W-1:0] rep(logic b);
    return b ? '1 : '0;
  endfunction

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cycle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset l_rdata", l_rdata, '1);
    check("R1 reset r_rdata", r_rdata, '1);
    rst_ni = 1'b1;
    cycle();
    drive_l(RD, 15'd0, '0); drive_r(RD, 15'd7, '0);
    cycle();
    check("R1 free after reset l", l_rdata, '1);
    check("R1 free after reset r", r_rdata, '1);

    for (int i = 0; i < NV; i++) begin
      drive_l(TBL[i].lo, ADDR_W'(TBL[i].la), dflt(TBL[i].lo));
      drive_r(TBL[i].ro, ADDR_W'(TBL[i].ra), dflt(TBL[i].ro));
      cycle();
      if (TBL[i].el != NC) check($sformatf("vector %0d left", i), l_rdata, rep(TBL[i].el[0]));
      if (TBL[i].er != NC) check($sformatf("vector %0d right", i), r_rdata, rep(TBL[i].er[0]));
    end

    // R4: upper address bits and upper data bits play no part
    drive_l(W0, {12'hABC, 3'd3}, 9'h1FE); drive_r(IDLE, '0, '0);
    cycle();
    drive_l(RD, 15'd3, '0); drive_r(RD, {12'h5A1, 3'd3}, '0);
    cycle();
    check("R4 request via junk bits l", l_rdata, '0);
    check("R4 request via junk bits r", r_rdata, '1);
    drive_l(W1, {12'h123, 3'd3}, 9'h001); drive_r(IDLE, '0, '0);
    cycle();
    drive_l(RD, {12'hFFF, 3'd3}, '0); drive_r(RD, 15'd3, '0);
    cycle();
    check("R4 release via bit0 l", l_rdata, '1);
    check("R4 release via bit0 r", r_rdata, '1);

    // R10: output register holds while the latch changes underneath
    drive_l(W0, 15'd3, '0); drive_r(IDLE, '0, '0);
    cycle();
    drive_l(RD, 15'd3, '0);
    cycle();
    check("R10 own read l", l_rdata, '0);
    drive_l(IDLE, '0, '0); drive_r(W0, 15'd3, '0);
    cycle();
    drive_l(W1, 15'd3, '1); drive_r(IDLE, '0, '0);
    cycle();
    drive_l(IDLE, '0, '0);
    cycle();
    check("R10 hold l", l_rdata, '0);
    check("R10 hold r", r_rdata, '1);
    drive_l(RD, 15'd3, '0); drive_r(RD, 15'd3, '0);
    cycle();
    check("R10 refreshed l", l_rdata, '1);
    check("R6 refreshed r", r_rdata, '0);

    // R1: reset in mid-run frees all tokens
    drive_l(W0, 15'd5, '0); drive_r(IDLE, '0, '0);
    cycle();
    drive_l(RD, 15'd5, '0);
    cycle();
    check("R1 pre-reset own l", l_rdata, '0);
    drive_l(IDLE, '0, '0);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset l_rdata", l_rdata, '1);
    cycle();
    rst_ni = 1'b1;
    cycle();
    drive_l(RD, 15'd5, '0); drive_r(RD, 15'd3, '0);
    cycle();
    check("R1 sem5 free l", l_rdata, '1);
    check("R1 sem3 free r", r_rdata, '1);
    drive_l(IDLE, '0, '0); drive_r(IDLE, '0, '0);
    cycle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule